// File: doc/BRIEF.md
# Partial-Queue Pseudo-LRU Replacement Tracker

This block keeps the replacement order for one cache set of `WAYS` ways. It models an ideal least-recently-used queue but stores only the `KEEP` positions nearest the eviction end. Each stored position holds a way number. The more recently used positions are not stored, so their order is not known and does not need to be. The way held in the oldest stored slot is always the victim.

An access strobe presents a way number, which is compared against the stored slots only. On a match, the slots on the newer side of the matching slot each move one step toward the eviction end, overwriting the matched entry. The newest stored slot is then refilled with a computed way number. That number is the smallest way absent from every stored slot, and it is derived from the slot contents alone, using gates only.

An access that matches no stored slot changes nothing, and the block reports that the state need not be written back. A replacement strobe consumes the current victim, as if that way had just been accessed. The state word is brought out so that a surrounding set array can store it.

Top module: `plru_partial_queue`

## Requirements
- R1: A synchronous reset, sampled on a rising clock edge, loads slot k with way number k for k = 0..KEEP-1. Slot 0 is the eviction end and sits in the least significant `IDW` bits of `state_word`, with slot k at bits [k*IDW +: IDW]. For 8 ways and 3 slots this gives `state_word` = 9'h088.
- R2: `victim_way` always equals the way number in slot 0.
- R3: An access whose way equals slot k shifts slots k+1..KEEP-1 one position toward slot 0 on the next edge, and leaves slots below k unchanged.
- R4: The newest slot (KEEP-1) is then loaded with the smallest way number that is absent from all stored slots as they stood before the update.
- R5: An access whose way matches no stored slot leaves `state_word` unchanged and holds `wr_needed` low.
- R6: `wr_needed` is high in a cycle exactly when a strobe in that cycle will change the state: a replacement, or an access that matches a stored slot.
- R7: A replacement strobe behaves as an access to the current `victim_way`.
- R8: When both strobes are high, the replacement is performed and the access way is ignored.
- R9: After an access to way w, none of the next KEEP replacements (with no access in between) selects w as the victim.
- R10: The stored slots always hold pairwise distinct way numbers.
- R11: With no strobe high, `state_word` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| acc_vld | input | 1 | Access strobe |
| acc_way | input | IDW | Way number being accessed |
| rpl_vld | input | 1 | Replacement strobe; consumes the victim |
| victim_way | output | IDW | Way to evict on the next fill |
| state_word | output | KEEP*IDW | Packed stored slots, slot 0 in the low bits |
| wr_needed | output | 1 | State changes on this edge and must be written back |

## Verification
The assertions assume that `acc_way` lies below `WAYS` and that the strobes are known whenever reset is low. Under these assumptions the distinct-slot invariant and the victim guard window follow from the update rule. The stimulus draws access ways only from the legal range. It mixes hits at each slot depth, misses into the unstored region, lone replacements and both strobes together. The guard window is exercised by long replacement-only runs after each access.

// File: rtl/plru_pkg.sv
package plru_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_TOUCH = 2'd1,
        OP_EVICT = 2'd2
    } plru_op_e;

    function automatic plru_op_e plru_decode_op(input logic touch, input logic evict);
        if (evict)      return OP_EVICT;
        else if (touch) return OP_TOUCH;
        else            return OP_NONE;
    endfunction

endpackage

// File: rtl/plru_match.sv
module plru_match #(
    parameter int WAYS = 8,
    parameter int KEEP = 3,
    localparam int IDW = $clog2(WAYS)
) (
    input  logic [KEEP-1:0][IDW-1:0] slots,
    input  logic [IDW-1:0]           way,
    output logic [KEEP-1:0]          hit_vec,
    output logic                     any_hit
);
    for (genvar k = 0; k < KEEP; k++) begin : g_cmp
        assign hit_vec[k] = (slots[k] == way);
    end

    assign any_hit = |hit_vec;
endmodule

// File: rtl/plru_fill.sv
module plru_fill #(
    parameter int WAYS = 8,
    parameter int KEEP = 3,
    localparam int IDW = $clog2(WAYS)
) (
    input  logic [KEEP-1:0][IDW-1:0] slots,
    output logic [IDW-1:0]           fill_way
);
    logic [WAYS-1:0] present;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [KEEP-1:0] eq;
        for (genvar k = 0; k < KEEP; k++) begin : g_slot
            assign eq[k] = (slots[k] == IDW'(w));
        end
        assign present[w] = |eq;
    end

    // Lowest absent way wins: scan from the top so the last hit is the smallest.
    always_comb begin
        fill_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!present[w]) fill_way = IDW'(w);
        end
    end
endmodule

// File: rtl/plru_shift.sv
module plru_shift #(
    parameter int WAYS = 8,
    parameter int KEEP = 3,
    localparam int IDW = $clog2(WAYS)
) (
    input  logic [KEEP-1:0][IDW-1:0] slots,
    input  logic [KEEP-1:0]          hit_vec,
    input  logic [IDW-1:0]           fill_way,
    output logic [KEEP-1:0][IDW-1:0] slots_nxt
);
    // at_or_above[j]: the hit lies at position j or nearer the eviction end.
    logic [KEEP-1:0] at_or_above;

    assign at_or_above[0] = hit_vec[0];
    for (genvar j = 1; j < KEEP; j++) begin : g_prefix
        assign at_or_above[j] = at_or_above[j-1] | hit_vec[j];
    end

    for (genvar j = 0; j < KEEP; j++) begin : g_slot
        if (j == KEEP - 1) begin : g_top
            assign slots_nxt[j] = at_or_above[j] ? fill_way : slots[j];
        end else begin : g_mid
            assign slots_nxt[j] = at_or_above[j] ? slots[j+1] : slots[j];
        end
    end
endmodule

// File: rtl/plru_partial_queue.sv
module plru_partial_queue #(
    parameter int WAYS = 8,
    parameter int KEEP = 3,
    localparam int IDW = $clog2(WAYS),
    localparam int SW  = KEEP * IDW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           acc_vld,
    input  logic [IDW-1:0] acc_way,
    input  logic           rpl_vld,
    output logic [IDW-1:0] victim_way,
    output logic [SW-1:0]  state_word,
    output logic           wr_needed
);
    import plru_pkg::*;

    typedef struct packed {
        logic [KEEP-1:0][IDW-1:0] slots;
    } trk_t;

    trk_t st_d, st_q;
    trk_t st_init;

    plru_op_e                 op;
    logic [IDW-1:0]           eff_way;
    logic [KEEP-1:0]          hit_vec;
    logic                     any_hit;
    logic [IDW-1:0]           fill_way;
    logic [KEEP-1:0][IDW-1:0] shifted;
    logic                     wr_d;

    for (genvar k = 0; k < KEEP; k++) begin : g_init
        assign st_init.slots[k] = IDW'(k);
    end

    assign op      = plru_decode_op(acc_vld, rpl_vld);
    assign eff_way = (op == OP_EVICT) ? st_q.slots[0] : acc_way;

    plru_match #(.WAYS(WAYS), .KEEP(KEEP)) u_match (
        .slots   (st_q.slots),
        .way     (eff_way),
        .hit_vec (hit_vec),
        .any_hit (any_hit)
    );

    plru_fill #(.WAYS(WAYS), .KEEP(KEEP)) u_fill (
        .slots    (st_q.slots),
        .fill_way (fill_way)
    );

    plru_shift #(.WAYS(WAYS), .KEEP(KEEP)) u_shift (
        .slots     (st_q.slots),
        .hit_vec   (hit_vec),
        .fill_way  (fill_way),
        .slots_nxt (shifted)
    );

    always_comb begin
        st_d = st_q;
        wr_d = 1'b0;
        if (op != OP_NONE && any_hit) begin
            st_d.slots = shifted;
            wr_d       = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       st_q <= st_init;
        else if (wr_d) st_q <= st_d;
    end

    assign victim_way = st_q.slots[0];
    assign state_word = st_q.slots;
    assign wr_needed  = wr_d;
endmodule

// File: rtl/plru_partial_queue_chk.sv
module plru_partial_queue_chk #(
    parameter int WAYS = 8,
    parameter int KEEP = 3,
    localparam int IDW = $clog2(WAYS),
    localparam int SW  = KEEP * IDW
) (
    input logic           clk,
    input logic           rst,
    input logic           acc_vld,
    input logic [IDW-1:0] acc_way,
    input logic           rpl_vld,
    input logic [IDW-1:0] victim_way,
    input logic [SW-1:0]  state_word,
    input logic           wr_needed
);
    logic           prev_rst;
    logic           guard_vld;
    logic [IDW-1:0] guard_way;
    int unsigned    guard_cnt;
    logic           dup;
    logic [SW-1:0]  init_word;

    always_comb begin
        init_word = '0;
        for (int k = 0; k < KEEP; k++) init_word[k*IDW +: IDW] = IDW'(k);
    end

    always_comb begin
        dup = 1'b0;
        for (int a = 0; a < KEEP; a++)
            for (int b = a + 1; b < KEEP; b++)
                if (state_word[a*IDW +: IDW] == state_word[b*IDW +: IDW]) dup = 1'b1;
    end

    always_ff @(posedge clk) begin
        prev_rst <= rst;
        if (rst) begin
            guard_vld <= 1'b0;
            guard_way <= '0;
            guard_cnt <= 0;
        end else if (rpl_vld) begin
            if (guard_cnt < KEEP) guard_cnt <= guard_cnt + 1;
        end else if (acc_vld) begin
            guard_vld <= 1'b1;
            guard_way <= acc_way;
            guard_cnt <= 0;
        end
    end

    always_ff @(posedge clk) begin
        if (prev_rst && !rst) begin
            assert_reset_order_R1: assert (state_word == init_word);
        end
    end

    assert_victim_slot0_R2: assert property (@(posedge clk) disable iff (rst)
        victim_way == state_word[IDW-1:0]);

    assert_lower_slot_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && !rpl_vld && wr_needed && acc_way != victim_way)
        |=> state_word[IDW-1:0] == $past(state_word[IDW-1:0]));

    assert_miss_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && !rpl_vld && !wr_needed) |=> $stable(state_word));

    assert_evict_writes_R6: assert property (@(posedge clk) disable iff (rst)
        rpl_vld |-> wr_needed);

    assert_victim_leaves_R7: assert property (@(posedge clk) disable iff (rst)
        rpl_vld |=> victim_way != $past(victim_way));

    assert_guard_window_R9: assert property (@(posedge clk) disable iff (rst)
        (rpl_vld && guard_vld && guard_cnt < KEEP) |-> victim_way != guard_way);

    assert_distinct_R10: assert property (@(posedge clk) disable iff (rst) !dup);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!acc_vld && !rpl_vld) |=> $stable(state_word));
endmodule

bind plru_partial_queue plru_partial_queue_chk #(.WAYS(WAYS), .KEEP(KEEP)) u_chk (.*);

// File: tb/plru_partial_queue_tb.sv
module plru_partial_queue_tb;
    localparam int WAYS = 8;
    localparam int KEEP = 3;
    localparam int IDW  = $clog2(WAYS);
    localparam int SW   = KEEP * IDW;

    logic           clk = 1'b0;
    logic           rst;
    logic           acc_vld;
    logic [IDW-1:0] acc_way;
    logic           rpl_vld;
    logic [IDW-1:0] victim_way;
    logic [SW-1:0]  state_word;
    logic           wr_needed;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int mq[$];
    bit g_vld = 0;
    int g_way = 0;
    int g_cnt = 0;

    always #4 clk = ~clk;

    plru_partial_queue #(.WAYS(WAYS), .KEEP(KEEP)) u_dut (
        .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_way(acc_way),
        .rpl_vld(rpl_vld), .victim_way(victim_way),
        .state_word(state_word), .wr_needed(wr_needed)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model_word();
        int w = 0;
        for (int k = 0; k < KEEP; k++) w |= mq[k] << (k * IDW);
        return w;
    endfunction

    task automatic model_reset();
        mq.delete();
        for (int k = 0; k < KEEP; k++) mq.push_back(k);
        g_vld = 0;
        g_cnt = 0;
    endtask

    task automatic compare_state(input string req);
        int dupc = 0;
        chk(int'(state_word) == model_word(), req, int'(state_word), model_word());
        chk(int'(victim_way) == mq[0], "R2", int'(victim_way), mq[0]);
        for (int a = 0; a < KEEP; a++)
            for (int b = a + 1; b < KEEP; b++)
                if (state_word[a*IDW +: IDW] == state_word[b*IDW +: IDW]) dupc++;
        chk(dupc == 0, "R10", dupc, 0);
    endtask

    // One operation: drive at the falling edge, check the write flag, update the model on the rising edge.
    task automatic op(input bit a, input int w, input bit r, input string req);
        int eff, pos, fillv;
        bit inq;
        acc_vld = a;
        acc_way = IDW'(w);
        rpl_vld = r;
        #1;
        eff = r ? mq[0] : w;
        pos = -1;
        for (int k = 0; k < KEEP; k++) if (mq[k] == eff) pos = k;
        chk(wr_needed == ((a || r) && pos >= 0), "R6", int'(wr_needed), int'((a || r) && pos >= 0));
        if (r && g_vld && g_cnt < KEEP)
            chk(mq[0] != g_way, "R9", mq[0], g_way);
        if ((a || r) && pos >= 0) begin
            fillv = -1;
            for (int v = WAYS - 1; v >= 0; v--) begin
                inq = 0;
                foreach (mq[k]) if (mq[k] == v) inq = 1;
                if (!inq) fillv = v;
            end
            mq.delete(pos);
            mq.push_back(fillv);
        end
        if (r) begin
            if (g_cnt < KEEP) g_cnt++;
        end else if (a) begin
            g_vld = 1; g_way = w; g_cnt = 0;
        end
        @(negedge clk);
        compare_state(req);
    endtask

    task automatic expect_word(input int exp, input string req);
        chk(int'(state_word) == exp, req, int'(state_word), exp);
    endtask

    initial begin
        rst = 1; acc_vld = 1; acc_way = 3'd5; rpl_vld = 1;
        repeat (3) @(negedge clk);
        rst = 0; acc_vld = 0; rpl_vld = 0;
        model_reset();
        #1;
        expect_word(9'h088, "R1");
        chk(int'(victim_way) == 0, "R1", int'(victim_way), 0);

        op(0, 0, 0, "R11");  expect_word(9'h088, "R11");
        op(1, 1, 0, "R3");   expect_word((3<<6)|(2<<3)|0, "R3");   // [0,2,3]
        op(1, 5, 0, "R5");   expect_word((3<<6)|(2<<3)|0, "R5");
        op(0, 0, 1, "R7");   expect_word((1<<6)|(3<<3)|2, "R7");   // [2,3,1]
        op(1, 3, 1, "R8");   expect_word((0<<6)|(1<<3)|3, "R8");   // [3,1,0]
        op(1, 0, 0, "R4");   expect_word((2<<6)|(1<<3)|3, "R4");   // [3,1,2]

        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 9);
            if (sel < 5)      op(1, $urandom_range(0, WAYS - 1), 0, "R3");
            else if (sel < 7) op(0, 0, 1, "R7");
            else if (sel < 8) op(1, $urandom_range(0, WAYS - 1), 1, "R8");
            else if (sel < 9) op(0, 0, 0, "R11");
            else begin
                op(1, $urandom_range(0, WAYS - 1), 0, "R9");
                for (int j = 0; j < KEEP + 1; j++) op(0, 0, 1, "R9");
            end
        end

        rst = 1;
        @(negedge clk);
        rst = 0;
        model_reset();
        #1;
        expect_word(9'h088, "R1");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule